// File: doc/BRIEF.md
# Small-Float Symmetric Saturation Clamp

This block limits a number held in a compact 8-bit floating-point format so that it never leaves a symmetric window centred on zero. Each cycle it receives a value word and a limit word, both in the same format. When the value's magnitude does not exceed the limit's magnitude, the value passes through untouched. Otherwise the block outputs the limit's exponent and magnitude with the value's sign, and it raises a saturation flag.

The format uses a signed exponent and a sign-magnitude mantissa. Words are not required to be normalised, so two different bit patterns can encode the same number. For that reason a compare of the raw words would give wrong results. The block instead shifts both mantissas onto one unsigned fixed-point grid and compares them there. The value and the limit are aligned by two side-by-side units, and the whole decision completes in one pass with no sequencing.

A parameter selects whether the result is registered. When it is registered, the output word, the flag and a valid bit that follows the input valid all move together with one cycle of latency. An upstream compute engine drives the block, and the next stage reads its output.

Top module: `sfp_clamp`

## Requirements
- R1: A word's bits [7:5] hold a two's-complement exponent e in the range -4..+3, bit [4] holds the sign, and bits [3:0] hold the unsigned magnitude m. The word's value is ±m·2^e, and every bit pattern is an ordinary number. If |value| ≤ |limit|, the output word equals the value word and the flag is 0.
- R2: If |value| > |limit|, the output word is {limit[7:5], value[4], limit[3:0]} and the flag is 1.
- R3: Bit [4] of the limit word has no effect on any output. The limit is always taken as positive.
- R4: A value whose magnitude equals the limit's magnitude is not flagged, even when the two words use different encodings of that magnitude.
- R5: A value with magnitude field 0 is never saturated, whatever its exponent and sign.
- R6: A limit with magnitude field 0 makes every value with a nonzero magnitude field saturate to a zero that carries the value's sign.
- R7: With the output register enabled (the default), the output word, the flag and the output valid show the inputs of the previous clock edge, and the output valid equals the input valid from that edge.
- R8: A synchronous active-high reset clears the output word, the flag and the output valid to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the input words as meaningful |
| value_in | input | 8 | Value to clamp |
| limit_in | input | 8 | Clamp limit; its sign bit is ignored |
| out_valid | output | 1 | Input valid carried alongside the result |
| result_out | output | 8 | Clamped word |
| sat_out | output | 1 | High when the value was replaced by the limit |

## Verification
A wrong shift in alignment, or a compare that used the raw words, would show up in the first cycle a bad pair reached the register. It would appear at the ports as a missing or false flag, or as a word that mixes value and limit fields. The full sweep of all value and limit pairs exposes any such error within one cycle of the pair being applied. A valid or reset path that drifts out of step with the data shows as an output valid that does not match the input valid one edge earlier, or as nonzero outputs right after reset.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    parameter int EXP_W  = 3;
    parameter int MAG_W  = 4;
    parameter int WORD_W = EXP_W + 1 + MAG_W;
    // largest left shift once the exponent is biased to be non-negative
    parameter int SHIFT_MAX = (1 << EXP_W) - 1;
    parameter int FIX_W     = MAG_W + SHIFT_MAX;

    typedef struct packed {
        logic [EXP_W-1:0] expo;
        logic             sgn;
        logic [MAG_W-1:0] mag;
    } sfp_word_t;

    typedef logic [FIX_W-1:0] sfp_fix_t;

    typedef struct packed {
        sfp_word_t word;
        logic      sat;
        logic      vld;
    } sfp_result_t;

    // Adding half the exponent range to a two's-complement number
    // is the same as inverting its top bit.
    function automatic logic [EXP_W-1:0] biased_shift(input logic [EXP_W-1:0] e);
        logic [EXP_W-1:0] r;
        r = e;
        r[EXP_W-1] = ~e[EXP_W-1];
        return r;
    endfunction

endpackage

// File: rtl/sfp_align.sv
module sfp_align
    import sfp_pkg::*;
(
    input  logic [EXP_W-1:0] expo,
    input  logic [MAG_W-1:0] mag,
    output sfp_fix_t         fix
);
    logic [EXP_W-1:0] shamt;
    sfp_fix_t         stage [EXP_W+1];

    assign shamt    = biased_shift(expo);
    assign stage[0] = sfp_fix_t'(mag);

    // logarithmic shifter, one stage per exponent bit
    for (genvar i = 0; i < EXP_W; i++) begin : g_shift
        assign stage[i+1] = shamt[i] ? (stage[i] << (1 << i)) : stage[i];
    end

    assign fix = stage[EXP_W];
endmodule

// File: rtl/sfp_mag_cmp.sv
module sfp_mag_cmp #(
    parameter int W = 11
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_gt_b
);
    assign a_gt_b = (a > b);
endmodule

// File: rtl/sfp_sat_select.sv
module sfp_sat_select
    import sfp_pkg::*;
(
    input  sfp_word_t value_w,
    input  sfp_word_t limit_w,
    input  logic      over,
    output sfp_word_t out_w
);
    sfp_word_t clipped;

    always_comb begin
        clipped     = limit_w;
        clipped.sgn = value_w.sgn;
        out_w       = over ? clipped : value_w;
    end
endmodule

// File: rtl/sfp_clamp.sv
module sfp_clamp
    import sfp_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] value_in,
    input  logic [WORD_W-1:0] limit_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] result_out,
    output logic              sat_out
);
    sfp_word_t   val_w;
    sfp_word_t   lim_w;
    sfp_fix_t    val_fix;
    sfp_fix_t    lim_fix;
    logic        over;
    sfp_word_t   sel_w;
    sfp_result_t nxt;
    sfp_result_t cur;

    assign val_w = sfp_word_t'(value_in);
    assign lim_w = sfp_word_t'(limit_in);

    // both operands aligned side by side
    sfp_align u_align_val (.expo(val_w.expo), .mag(val_w.mag), .fix(val_fix));
    sfp_align u_align_lim (.expo(lim_w.expo), .mag(lim_w.mag), .fix(lim_fix));

    sfp_mag_cmp #(.W(FIX_W)) u_cmp (.a(val_fix), .b(lim_fix), .a_gt_b(over));

    sfp_sat_select u_sel (
        .value_w(val_w),
        .limit_w(lim_w),
        .over   (over),
        .out_w  (sel_w)
    );

    assign nxt = '{word: sel_w, sat: over, vld: in_valid};

    if (REGISTER_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) cur <= '0;
            else     cur <= nxt;
        end
    end else begin : g_comb
        assign cur = nxt;
    end

    assign result_out = cur.word;
    assign sat_out    = cur.sat;
    assign out_valid  = cur.vld;
endmodule

// File: rtl/sfp_clamp_checker.sv
module sfp_clamp_checker #(
    parameter bit REGISTER_OUT = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] value_in,
    input logic [7:0] limit_in,
    input logic       out_valid,
    input logic [7:0] result_out,
    input logic       sat_out
);
    logic [7:0] ref_v;
    logic [7:0] ref_l;
    logic       ref_vld;

    if (REGISTER_OUT) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst) begin
                ref_v <= '0; ref_l <= '0; ref_vld <= 1'b0;
            end else begin
                ref_v <= value_in; ref_l <= limit_in; ref_vld <= in_valid;
            end
        end
    end else begin : g_now
        assign ref_v   = value_in;
        assign ref_l   = limit_in;
        assign ref_vld = in_valid;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        out_valid == ref_vld); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !sat_out && result_out == 8'h00)); // R8

    AST_SAT_FIELDS: assert property (@(posedge clk) disable iff (rst)
        sat_out |-> result_out == ((ref_l & 8'hEF) | (ref_v & 8'h10))); // R2

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !sat_out |-> result_out == ref_v); // R1

    AST_ZERO_VALUE: assert property (@(posedge clk) disable iff (rst)
        ref_v[3:0] == 4'h0 |-> !sat_out); // R5

    AST_EQUAL_NOT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (ref_v[7:5] == ref_l[7:5] && ref_v[3:0] == ref_l[3:0]) |-> !sat_out); // R4

    AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (ref_l[3:0] == 4'h0 && ref_v[3:0] != 4'h0) |-> (sat_out && result_out[3:0] == 4'h0)); // R6
endmodule

bind sfp_clamp sfp_clamp_checker #(.REGISTER_OUT(REGISTER_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .value_in  (value_in),
    .limit_in  (limit_in),
    .out_valid (out_valid),
    .result_out(result_out),
    .sat_out   (sat_out)
);

// File: tb/sfp_clamp_test.sv
module sfp_clamp_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] value_in;
    logic [7:0] limit_in;
    wire logic       out_valid;
    wire logic [7:0] result_out;
    wire logic       sat_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    sfp_clamp uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .value_in(value_in), .limit_in(limit_in),
        .out_valid(out_valid), .result_out(result_out), .sat_out(sat_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // magnitude of a word as a real number
    function automatic real mag_real(input logic [7:0] w);
        int  e;
        real r;
        e = w[7] ? int'(w[7:5]) - 8 : int'(w[7:5]);
        r = real'(int'(w[3:0]));
        for (int i = 0; i < e; i++) r = r * 2.0;
        for (int i = 0; i > e; i--) r = r / 2.0;
        return r;
    endfunction

    task automatic check_bits(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [7:0] v, input logic [7:0] l, input logic vld);
        real        av, al;
        logic       exp_sat;
        logic [7:0] exp_w;
        string      tag;
        @(negedge clk);
        value_in = v; limit_in = l; in_valid = vld;
        @(posedge clk);
        #1;
        av = mag_real(v);
        al = mag_real(l);
        exp_sat = (av > al);
        exp_w   = exp_sat ? {l[7:5], v[4], l[3:0]} : v;
        if (exp_sat)             tag = (l[3:0] == 0) ? "R6" : "R2";
        else if (v[3:0] == 0)    tag = "R5";
        else if (av == al)       tag = "R4";
        else                     tag = "R1";
        if (l[4]) tag = {tag, "/R3"};
        check_bits({tag, " word"}, result_out, exp_w);
        check_bits({tag, " flag"}, {7'd0, sat_out}, {7'd0, exp_sat});
        check_bits("R7 valid", {7'd0, out_valid}, {7'd0, vld});
    endtask

    task automatic check_cleared(input string tag);
        check_bits({tag, " word"}, result_out, 8'h00);
        check_bits({tag, " flag"}, {7'd0, sat_out}, 8'h00);
        check_bits({tag, " valid"}, {7'd0, out_valid}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; in_valid = 1'b1; value_in = 8'h7F; limit_in = 8'h01;
        repeat (3) @(posedge clk);
        #1;
        check_cleared("R8 reset");
        @(negedge clk); rst = 1'b0;

        // directed corners
        apply(8'h02, 8'h21, 1'b1);   // R4: 2*2^0 equals 1*2^1
        apply(8'h13, 8'h60, 1'b1);   // R6: zero limit, negative value -> 8'h70
        apply(8'h70, 8'h81, 1'b1);   // R5: zero value never clipped
        apply(8'h46, 8'h55, 1'b1);   // R3: limit sign set, result 8'h45
        apply(8'h46, 8'h45, 1'b0);   // R3 companion with sign clear, R7 low valid
        apply(8'h9F, 8'h7F, 1'b1);   // R1: smallest exponent passes
        apply(8'h7F, 8'h9F, 1'b1);   // R2: largest value against tiny limit

        // mid-stream reset
        @(negedge clk); rst = 1'b1; in_valid = 1'b1; value_in = 8'h7F; limit_in = 8'h00;
        @(posedge clk); #1;
        check_cleared("R8 mid reset");
        @(negedge clk); rst = 1'b0;

        // exhaustive sweep with random valid
        for (int v = 0; v < 256; v++)
            for (int l = 0; l < 256; l++)
                apply(8'(v), 8'(l), 1'($urandom));

        // random tail
        for (int k = 0; k < 2000; k++)
            apply(8'($urandom), 8'($urandom), 1'($urandom));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule